// File: doc/BRIEF.md
# Atomic Bus Lock Controller

This block owns the processor side of a shared, wired-AND bus lock line. The line is active low and held high by an external pull-up. Several agents can pull it low, and the block does so through an open-drain enable. When the core wants an indivisible read-modify-write, it raises a request. The block grants the request only after it has seen the line released by every other agent. From the grant it holds the line low through the address phase of the read, and it lets the line go in the address phase of the write that ends the sequence. Interrupt-acknowledge address phases also pull the line low while they last. Ordinary reads and writes are never held back by a lock that another agent holds; only the start of a new atomic sequence waits.

The block learns the state of the line through its sampled input. It counts the line as taken by someone else only when the line is low while the block is not holding it. The block samples the line once at the first clock after reset is released. If the line is low at that edge, the block enters an isolation state. In that state it drives nothing and tells the pad ring to float every output, until the next reset.

Top module: `bus_lock_ctrl`

## Requirements
- R1: Before the first clock edge after reset release, `lock_oe_o`, `lock_granted_o` and `isolate_o` are all 0.
- R2: If `lock_line_i` is 0 at the first rising edge after reset release, `isolate_o` goes to 1. From then until the next reset, `lock_oe_o` and `lock_granted_o` stay 0 whatever the requests and address phases.
- R3: If `lock_line_i` is 1 at that edge, `isolate_o` stays 0 and normal operation starts.
- R4: While the block is idle, a request (`rmw_req_i`=1) seen at a clock edge with `lock_line_i`=0 and the block not holding the line gives no grant and no drive. The block samples the line again at every edge until it finds the line free.
- R5: A request seen at an edge with `lock_line_i`=1 sets `lock_oe_o` and `lock_granted_o` to 1 from the next cycle on. Sampling the line and taking it happen in one step, so the line is never taken on a busy sample.
- R6: An address phase (`addr_phase_i`=1) of kind 2'b01 (atomic read) while granted keeps `lock_oe_o` at 1 in that cycle and afterwards. `lock_granted_o` falls to 0 in the following cycle.
- R7: An address phase of kind 2'b10 (atomic write) after the atomic read sets `lock_oe_o` to 0 within that same cycle. The output stays 0 afterwards, and a new request must win a fresh sample of the line.
- R8: An address phase of kind 2'b11 (interrupt acknowledge) sets `lock_oe_o` to 1 for that cycle outside isolation, even while another agent holds the line.
- R9: An address phase of kind 2'b00 (plain access) changes neither `lock_oe_o` nor `lock_granted_o`, whether or not another agent holds the line.
- R10: `lock_oe_o` is the only way the block acts on the line, and 1 means pull low. The block never drives the line high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rmw_req_i | input | 1 | Core asks to start an atomic sequence; held until granted |
| addr_phase_i | input | 1 | Current cycle is a bus address phase |
| txn_kind_i | input | 2 | Kind of the address phase: 00 plain, 01 atomic read, 10 atomic write, 11 interrupt acknowledge |
| lock_line_i | input | 1 | Sampled level of the shared lock line (0 = held) |
| lock_oe_o | output | 1 | Open-drain enable; 1 pulls the lock line low |
| lock_granted_o | output | 1 | Core may issue the atomic read address phase |
| isolate_o | output | 1 | Isolation state; all block outputs to be floated by the pad ring |

## Verification
The assertions take for granted that the core keeps the bus protocol. It issues an atomic-read address phase only while `lock_granted_o` is high, and an atomic-write address phase only after that read. They also take for granted that `lock_line_i` is already synchronous to `clk_i`. The stimulus keeps to this: every atomic read in the vector table follows a cycle in which the grant was seen, and every atomic write follows its read. The model of the second agent and the pull-up is combinational, and the bench changes it only at falling edges.

// File: rtl/bus_lock_pkg.sv
package bus_lock_pkg;
  localparam int unsigned KIND_W = 2;

  typedef enum logic [KIND_W-1:0] {
    KIND_PLAIN = 2'b00,
    KIND_RD    = 2'b01,
    KIND_WR    = 2'b10,
    KIND_IACK  = 2'b11
  } txn_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_GRANT  = 2'b01,
    ST_LOCKED = 2'b10
  } lock_state_e;
endpackage

// File: rtl/bus_lock_mode_sampler.sv
module bus_lock_mode_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_line_i,
  output logic sampled_o,
  output logic isolate_o
);
  logic sampled_q, iso_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sampled_q <= 1'b0;
      iso_q     <= 1'b0;
    end else if (!sampled_q) begin
      sampled_q <= 1'b1;
      iso_q     <= !lock_line_i;
    end
  end

  assign sampled_o = sampled_q;
  assign isolate_o = iso_q;

  // R2: mode is frozen once chosen
  p_iso_frozen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sampled_q |=> $stable(iso_q));
endmodule

// File: rtl/bus_lock_fsm.sv
module bus_lock_fsm
  import bus_lock_pkg::*;
#(
  parameter int unsigned KW = KIND_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic          rmw_req_i,
  input  logic          addr_phase_i,
  input  logic [KW-1:0] txn_kind_i,
  input  logic          lock_line_i,
  output logic          hold_o,
  output logic          release_o,
  output logic          granted_o
);
  lock_state_e state_q, state_d;
  logic busy, rd_ta, wr_ta;

  assign hold_o    = (state_q != ST_IDLE);
  // line low while this block is not holding it: another agent has it
  assign busy      = !lock_line_i && !hold_o;
  assign rd_ta     = addr_phase_i && (txn_kind_i == KIND_RD);
  assign wr_ta     = addr_phase_i && (txn_kind_i == KIND_WR);
  assign release_o = (state_q == ST_LOCKED) && wr_ta;
  assign granted_o = (state_q == ST_GRANT);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (active_i && rmw_req_i && !busy) state_d = ST_GRANT;
      ST_GRANT:  if (rd_ta) state_d = ST_LOCKED;
      ST_LOCKED: if (wr_ta) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  p_no_grant_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && busy) |=> !granted_o);
  p_read_keeps_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (granted_o && rd_ta) |=> (hold_o && !granted_o));
  p_write_frees_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_o |=> !hold_o);
endmodule

// File: rtl/bus_lock_ctrl.sv
module bus_lock_ctrl
  import bus_lock_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rmw_req_i,
  input  logic              addr_phase_i,
  input  logic [KIND_W-1:0] txn_kind_i,
  input  logic              lock_line_i,
  output logic              lock_oe_o,
  output logic              lock_granted_o,
  output logic              isolate_o
);
  logic sampled, iso, active, hold, release_now, granted, iack_ta;

  bus_lock_mode_sampler u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lock_line_i (lock_line_i),
    .sampled_o   (sampled),
    .isolate_o   (iso)
  );

  assign active = sampled && !iso;

  bus_lock_fsm #(.KW(KIND_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .active_i     (active),
    .rmw_req_i    (rmw_req_i),
    .addr_phase_i (addr_phase_i),
    .txn_kind_i   (txn_kind_i),
    .lock_line_i  (lock_line_i),
    .hold_o       (hold),
    .release_o    (release_now),
    .granted_o    (granted)
  );

  assign iack_ta        = addr_phase_i && (txn_kind_i == KIND_IACK);
  // open-drain: only an enable to pull low exists
  assign lock_oe_o      = active && ((hold && !release_now) || iack_ta);
  assign lock_granted_o = active && granted;
  assign isolate_o      = iso;

  p_iso_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iso |-> (!lock_oe_o && !lock_granted_o));
  p_grant_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_granted_o |-> lock_oe_o);
  p_iack_drives_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && iack_ta) |-> lock_oe_o);
  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sampled) |-> (!lock_oe_o && !lock_granted_o));
endmodule

// File: tb/bus_lock_ctrl_test.sv
`timescale 1ns/1ps
module bus_lock_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, ta = 1'b0, agent = 1'b0;
  logic [1:0] kind = 2'b00;
  logic       lock_oe, gnt, iso, line;
  int         checks = 0, errors = 0;

  always #5 clk = ~clk;

  // wired-AND line with pull-up: low if anyone pulls
  assign line = !(lock_oe || agent);

  bus_lock_ctrl uut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .rmw_req_i      (req),
    .addr_phase_i   (ta),
    .txn_kind_i     (kind),
    .lock_line_i    (line),
    .lock_oe_o      (lock_oe),
    .lock_granted_o (gnt),
    .isolate_o      (iso)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // {req, ta, kind[1:0], agent, exp_oe, exp_gnt}
  localparam int NV = 24;
  localparam logic [6:0] VEC [NV] = '{
    7'b0_0_00_0_0_0, // 0 idle
    7'b1_0_00_1_0_0, // 1 R4 busy
    7'b1_1_00_1_0_0, // 2 R9 plain during foreign hold
    7'b1_0_00_0_0_0, // 3 free, grant at edge
    7'b0_0_00_0_1_1, // 4 R5
    7'b0_1_01_0_1_1, // 5 R6 read phase
    7'b0_0_00_0_1_0, // 6 R6 locked
    7'b0_1_00_0_1_0, // 7 R9 plain while locked
    7'b0_1_10_0_0_0, // 8 R7 write releases
    7'b0_0_00_0_0_0, // 9 R7
    7'b0_1_11_0_1_0, // 10 R8 iack
    7'b0_0_00_0_0_0, // 11 R8 end
    7'b1_0_00_0_0_0, // 12 free
    7'b0_0_00_0_1_1, // 13 R5
    7'b0_1_01_0_1_1, // 14 R6
    7'b0_1_10_0_0_0, // 15 R7
    7'b0_0_00_0_0_0, // 16
    7'b0_1_11_1_1_0, // 17 R8 iack with foreign hold
    7'b0_0_00_0_0_0, // 18
    7'b1_0_00_1_0_0, // 19 R4
    7'b1_0_00_0_0_0, // 20 freed
    7'b0_0_00_0_1_1, // 21 R5
    7'b0_1_01_0_1_1, // 22 R6
    7'b0_1_10_0_0_0  // 23 R7
  };

  function automatic string tag_of(input int row);
    case (row)
      1, 19:             return "R4";
      4, 13, 21:         return "R5";
      5, 6, 14, 22:      return "R6";
      8, 9, 15, 23:      return "R7";
      10, 11, 17:        return "R8";
      2, 7:              return "R9";
      default:           return "R10";
    endcase
  endfunction

  task automatic do_reset(input logic hold_low);
    @(negedge clk);
    rst_n = 1'b0; req = 1'b0; ta = 1'b0; kind = 2'b00; agent = hold_low;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "oe", lock_oe, 1'b0);
    chk("R1", "gnt", gnt, 1'b0);
    chk("R1", "iso", iso, 1'b0);
    @(negedge clk);
    agent = 1'b0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    chk("R3", "iso", iso, 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {req, ta, kind, agent} = VEC[i][6:2];
      #1;
      chk(tag_of(i), $sformatf("oe row %0d", i), lock_oe, VEC[i][1]);
      chk(tag_of(i), $sformatf("gnt row %0d", i), gnt, VEC[i][0]);
    end

    // R4: long foreign hold, no grant until released
    @(negedge clk);
    req = 1'b1; ta = 1'b0; kind = 2'b00; agent = 1'b1;
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      chk("R4", "gnt during foreign hold", gnt, 1'b0);
      chk("R4", "oe during foreign hold", lock_oe, 1'b0);
    end
    agent = 1'b0;
    @(negedge clk);
    req = 1'b0;
    chk("R5", "gnt after release", gnt, 1'b1);
    ta = 1'b1; kind = 2'b01;
    @(negedge clk);
    ta = 1'b1; kind = 2'b10;
    #1;
    chk("R7", "oe on write", lock_oe, 1'b0);
    @(negedge clk);
    ta = 1'b0;

    // R2: isolation entry
    do_reset(1'b1);
    chk("R2", "iso", iso, 1'b1);
    req = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      ta = k[0]; kind = 2'b11;
      #1;
      chk("R2", "oe in isolation", lock_oe, 1'b0);
      chk("R2", "gnt in isolation", gnt, 1'b0);
      chk("R2", "iso held", iso, 1'b1);
    end

    // R3: reset with line high leaves isolation
    do_reset(1'b0);
    chk("R3", "iso after clean reset", iso, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule